// File: doc/BRIEF.md
# Prioritized Interrupt Autovector Encoder

This block collects up to 32 interrupt request sources that share one processor interrupt line. Each source has a request latch that a one-cycle pulse sets. The latch stays set until software clears it through that source's write-one-to-clear strobe. A per-source enable masks the latch. The shared interrupt output is high whenever any enabled latch is set.

When the processor takes the shared interrupt, it fetches a three-byte jump instruction from a fixed entry address. The entry byte holds the opcode and the next byte holds the page of a jump table; both come from memory unchanged. When the third byte is fetched, the block replaces the memory byte with a vector. The vector is four times the bit index of the highest-priority pending, enabled source, so the branch lands on that source's slot in the table.

The block picks the vector at the moment the entry byte is fetched and holds it for the rest of the sequence. A request that arrives during the three fetches cannot change the target. A global enable turns substitution off, and the fetch path then passes memory data straight through.

Top module: `autovec_encoder`

## Requirements
- R1: After a synchronous active-low reset, every request latch is clear and `irq_o` is 0. A fetch of address 0x0045 returns the memory byte until a sequence has started at 0x0043.
- R2: A set request latch stays set on every cycle in which its clear strobe is 0.
- R3: A request pulse on a non-reserved source sets its latch at the next clock edge. A pulse and a clear for the same source in the same cycle leave the latch set. A clear without a pulse empties the latch.
- R4: `irq_o` is 1 exactly when at least one set latch has its enable bit at 1. A set latch whose enable is 0 does not raise `irq_o`.
- R5: Reserved sources never latch a request. With the default mask these are bit indices 7, 17, 25, 26 and 27 (priority slots 8, 18, 26, 27 and 28).
- R6: Among pending, enabled sources, bit index 0 (priority 1) wins over every higher index. The substituted byte is the winner's index times 4, from 0x00 for bit 0 up to 0x7C for bit 31.
- R7: Substitution happens only on a fetch of 0x0045 that follows a fetch of 0x0043. Fetches of 0x0043, 0x0044 and any other address return the memory byte.
- R8: With `av_en_i` at 0, a fetch of 0x0045 returns the memory byte.
- R9: The vector is captured on the fetch of 0x0043 and held until the fetch of 0x0045 completes. A higher-priority request that arrives between those fetches does not change the substituted byte.
- R10: If no source was pending and enabled when 0x0043 was fetched, the fetch of 0x0045 returns the memory byte.
- R11: After the fetch of 0x0045, the sequence ends. A further fetch of 0x0045 without a new fetch of 0x0043 returns the memory byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_pulse_i | input | 32 | Per-source request pulses, bit i = priority i+1 |
| req_en_i | input | 32 | Per-source enables |
| req_clr_i | input | 32 | Per-source write-one-to-clear strobes |
| av_en_i | input | 1 | Autovector substitution enable |
| fetch_valid_i | input | 1 | A code fetch is presented this cycle |
| fetch_addr_i | input | 16 | Code fetch address |
| mem_rdata_i | input | 8 | Byte read from code memory |
| irq_o | output | 1 | Shared interrupt request |
| fetch_data_o | output | 8 | Fetch byte delivered to the processor |

## Verification
On every cycle, the assertions check four things:
- latches hold and accept new pulses;
- reserved slots never latch;
- the winner the encoder reports is pending, with no pending source at a lower index;
- the held vector stays constant between the entry fetch and the end of the sequence, and data passes through unchanged when autovectoring is off.

Some behaviour only the bench scenarios can show. These are the exact vector bytes for chosen request and enable masks, and the page byte passing through. They also include a late higher-priority request failing to redirect an open sequence, and the sequence closing after its third byte.

// File: rtl/autovec_pkg.sv
// Package: shared types for the autovector encoder.
// Assumes: nothing beyond IEEE 1800-2017.
package autovec_pkg;

    // State of the three-byte jump fetch sequence
    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_ARMED = 1'b1
    } seq_state_e;

    // Vector spacing: slots are four bytes apart in the jump table
    localparam int VEC_SHIFT = 2;

endpackage

// File: rtl/req_latch_bank.sv
// Module: req_latch_bank
// Holds one sticky request latch per source. A pulse sets a latch and a
// clear strobe empties it; a pulse wins over a simultaneous clear.
// Slots marked in RESERVED_MASK are tied to zero and never latch.
// Assumes: pulses and clears are synchronous to clk.
module req_latch_bank #(
    parameter int                   NUM_SLOTS     = 32,
    parameter logic [NUM_SLOTS-1:0] RESERVED_MASK = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] pulse_i,
    input  logic [NUM_SLOTS-1:0] clr_i,
    output logic [NUM_SLOTS-1:0] lat_o
);

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        if (RESERVED_MASK[g]) begin : g_resv
            // Reserved slot: constant zero, request pulses ignored
            assign lat_o[g] = 1'b0;
        end else begin : g_live
            logic bit_q;
            // Sticky latch: set on pulse, cleared on strobe, pulse has priority
            always_ff @(posedge clk) begin
                if (!rst_n)          bit_q <= 1'b0;
                else if (pulse_i[g]) bit_q <= 1'b1;
                else if (clr_i[g])   bit_q <= 1'b0;
            end
            assign lat_o[g] = bit_q;
        end
    end

    // R2: set latches without a clear stay set
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(lat_o) & ~$past(clr_i)) & ~lat_o) == '0));

    // R3: a pulse on a live slot is latched at the next edge
    a_r3_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(pulse_i) & ~RESERVED_MASK) & ~lat_o) == '0));

    // R5: reserved slots never show a request
    a_r5_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_o & RESERVED_MASK) == '0);

endmodule

// File: rtl/prio_pick.sv
// Module: prio_pick
// Fixed-priority encoder: reports the lowest set bit index of req_i.
// Bit 0 is the highest priority. Purely combinational; clk and rst_n
// only qualify the checks.
// Assumes: NUM_SLOTS is a power of two or IDX_W covers it.
module prio_pick #(
    parameter int NUM_SLOTS = 32,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req_i,
    output logic                 valid_o,
    output logic [IDX_W-1:0]     idx_o
);

    // Scan from the lowest priority upward so the highest priority is kept last
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

    // R6: the reported winner is pending and nothing above it in priority is
    a_r6_highest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (req_i[idx_o] &&
                     ((req_i & ((NUM_SLOTS'(1) << idx_o) - NUM_SLOTS'(1))) == '0)));

    // R4: no winner only when nothing requests
    a_r4_none: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> (req_i == '0));

endmodule

// File: rtl/fetch_subst.sv
// Module: fetch_subst
// Watches the code fetch stream. A fetch of the entry address captures the
// current winner, and a later fetch of entry+2 has its byte replaced by the
// winner's vector. The sequence closes after the entry+2 fetch.
// Assumes: the processor fetches entry, entry+1, entry+2 in order after
// taking the shared interrupt; fetch data path is combinational.
module fetch_subst
    import autovec_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter int                IDX_W      = 5,
    parameter logic [ADDR_W-1:0] ENTRY_ADDR = 16'h0043
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              av_en_i,
    input  logic              fetch_valid_i,
    input  logic [ADDR_W-1:0] fetch_addr_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    input  logic              pick_valid_i,
    input  logic [IDX_W-1:0]  pick_idx_i,
    output logic [DATA_W-1:0] fetch_data_o
);

    localparam logic [ADDR_W-1:0] VEC_ADDR = ENTRY_ADDR + ADDR_W'(2);

    seq_state_e        seq_q;
    logic [IDX_W-1:0]  idx_q;
    logic              hit_q;
    logic              at_entry;
    logic              at_vec;
    logic [DATA_W-1:0] vec_byte;

    // Decode the two addresses of interest
    assign at_entry = fetch_valid_i && (fetch_addr_i == ENTRY_ADDR);
    assign at_vec   = fetch_valid_i && (fetch_addr_i == VEC_ADDR);

    // Track the sequence and freeze the winner on the entry fetch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
            idx_q <= '0;
            hit_q <= 1'b0;
        end else if (at_entry) begin
            seq_q <= SEQ_ARMED;
            idx_q <= pick_idx_i;
            hit_q <= pick_valid_i;
        end else if (at_vec) begin
            seq_q <= SEQ_IDLE;
        end
    end

    // Form the vector byte from the held index
    assign vec_byte = DATA_W'(idx_q) << VEC_SHIFT;

    // Replace the vector byte only inside an armed sequence with a winner
    always_comb begin
        if (at_vec && (seq_q == SEQ_ARMED) && hit_q && av_en_i)
            fetch_data_o = vec_byte;
        else
            fetch_data_o = mem_rdata_i;
    end

    // R9: the held winner does not move until a new entry fetch
    a_r9_hold_vec: assert property (@(posedge clk) disable iff (!rst_n)
        ((seq_q == SEQ_ARMED) && !at_entry) |=> ($stable(idx_q) && $stable(hit_q)));

    // R8: with autovectoring off the fetch data is the memory byte
    a_r8_pass: assert property (@(posedge clk) disable iff (!rst_n)
        !av_en_i |-> (fetch_data_o == mem_rdata_i));

    // R11: the vector fetch closes the sequence
    a_r11_close: assert property (@(posedge clk) disable iff (!rst_n)
        (at_vec && !at_entry) |=> (seq_q == SEQ_IDLE));

endmodule

// File: rtl/autovec_encoder.sv
// Module: autovec_encoder (top)
// Latches and masks up to NUM_SLOTS interrupt requests, drives one shared
// interrupt, and substitutes the winner's vector into the jump fetched at
// ENTRY_ADDR. Bit i of each source vector is priority i+1.
// Assumes: synchronous active-low reset, single clock domain.
module autovec_encoder #(
    parameter int                   NUM_SLOTS     = 32,
    parameter int                   ADDR_W        = 16,
    parameter int                   DATA_W        = 8,
    parameter logic [ADDR_W-1:0]    ENTRY_ADDR    = 16'h0043,
    parameter logic [NUM_SLOTS-1:0] RESERVED_MASK = 32'h0E02_0080
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] req_pulse_i,
    input  logic [NUM_SLOTS-1:0] req_en_i,
    input  logic [NUM_SLOTS-1:0] req_clr_i,
    input  logic                 av_en_i,
    input  logic                 fetch_valid_i,
    input  logic [ADDR_W-1:0]    fetch_addr_i,
    input  logic [DATA_W-1:0]    mem_rdata_i,
    output logic                 irq_o,
    output logic [DATA_W-1:0]    fetch_data_o
);

    localparam int IDX_W = $clog2(NUM_SLOTS);

    logic [NUM_SLOTS-1:0] lat;
    logic [NUM_SLOTS-1:0] live;
    logic                 pick_valid;
    logic [IDX_W-1:0]     pick_idx;

    req_latch_bank #(
        .NUM_SLOTS     (NUM_SLOTS),
        .RESERVED_MASK (RESERVED_MASK)
    ) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .pulse_i (req_pulse_i),
        .clr_i   (req_clr_i),
        .lat_o   (lat)
    );

    // Mask latched requests with their enables
    assign live  = lat & req_en_i;
    // Shared line: any enabled pending source
    assign irq_o = |live;

    prio_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (live),
        .valid_o (pick_valid),
        .idx_o   (pick_idx)
    );

    fetch_subst #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .IDX_W      (IDX_W),
        .ENTRY_ADDR (ENTRY_ADDR)
    ) u_subst (
        .clk           (clk),
        .rst_n         (rst_n),
        .av_en_i       (av_en_i),
        .fetch_valid_i (fetch_valid_i),
        .fetch_addr_i  (fetch_addr_i),
        .mem_rdata_i   (mem_rdata_i),
        .pick_valid_i  (pick_valid),
        .pick_idx_i    (pick_idx),
        .fetch_data_o  (fetch_data_o)
    );

    // R4: the shared line agrees with the encoder's view of pending work
    a_r4_irq_pick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == pick_valid);

    // R7: the page byte is never replaced
    a_r7_page_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid_i && (fetch_addr_i == ENTRY_ADDR + ADDR_W'(1)))
            |-> (fetch_data_o == mem_rdata_i));

endmodule

// File: tb/autovec_encoder_test.sv
module autovec_encoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] req_pulse, req_en, req_clr;
    logic        av_en, fetch_valid;
    logic [15:0] fetch_addr;
    logic [7:0]  mem_rdata;
    logic        irq;
    logic [7:0]  fetch_data;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #2 clk = ~clk;

    autovec_encoder uut (
        .clk(clk), .rst_n(rst_n), .req_pulse_i(req_pulse), .req_en_i(req_en),
        .req_clr_i(req_clr), .av_en_i(av_en), .fetch_valid_i(fetch_valid),
        .fetch_addr_i(fetch_addr), .mem_rdata_i(mem_rdata), .irq_o(irq),
        .fetch_data_o(fetch_data)
    );

    // Table: {pending mask, enable mask, expected vector, substitution expected}
    localparam logic [72:0] TBL [8] = '{
        {32'h0000_0001, 32'hFFFF_FFFF, 8'h00, 1'b1},
        {32'h8000_0000, 32'hFFFF_FFFF, 8'h7C, 1'b1},
        {32'h0000_0F00, 32'hFFFF_FFFF, 8'h20, 1'b1},
        {32'h0001_0020, 32'hFFFF_FFDF, 8'h40, 1'b1},
        {32'h0000_0080, 32'hFFFF_FFFF, 8'h00, 1'b0},
        {32'h1000_0000, 32'hFFFF_FFFF, 8'h70, 1'b1},
        {32'hFFFF_FFFF, 32'hFFFF_FF00, 8'h20, 1'b1},
        {32'h0000_0006, 32'h0000_0000, 8'h00, 1'b0}
    };

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic pulse(input logic [31:0] m);
        req_pulse = m;
        tick();
        req_pulse = '0;
    endtask

    task automatic clear(input logic [31:0] m);
        req_clr = m;
        tick();
        req_clr = '0;
    endtask

    task automatic fetch_at(input logic [15:0] a, input logic [7:0] exp, input string tag);
        fetch_valid = 1'b1;
        fetch_addr  = a;
        mem_rdata   = mem_byte(a);
        #1;
        chk(tag, fetch_data, exp);
        tick();
        fetch_valid = 1'b0;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; req_pulse = '0; req_en = '0; req_clr = '0;
        av_en = 1'b1; fetch_valid = 1'b0; fetch_addr = '0; mem_rdata = '0;
        req_pulse = 32'hFFFF_FFFF; req_en = 32'hFFFF_FFFF;
        tick(); tick(); tick();
        #1;
        chk("R1 irq in reset", {7'd0, irq}, 8'h00);
        req_pulse = '0;
        rst_n = 1'b1;
        #1;
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        fetch_at(16'h0045, mem_byte(16'h0045), "R1 no sequence");

        // Table-driven vectors
        for (int k = 0; k < 8; k++) begin
            logic [31:0] pend, en;
            logic [7:0]  vec;
            logic        sub;
            {pend, en, vec, sub} = TBL[k];
            clear(32'hFFFF_FFFF);
            req_en = en;
            pulse(pend);
            #1;
            chk("R4 irq", {7'd0, irq}, {7'd0, sub});
            fetch_at(16'h0043, mem_byte(16'h0043), "R7 opcode");
            fetch_at(16'h0044, mem_byte(16'h0044), "R7 page");
            fetch_at(16'h0045, sub ? vec : mem_byte(16'h0045), sub ? "R6 vector" : "R10 no winner");
        end

        // R5: reserved slot pulse does not latch
        clear(32'hFFFF_FFFF);
        req_en = 32'hFFFF_FFFF;
        pulse(32'h0002_0000);
        #1;
        chk("R5 reserved", {7'd0, irq}, 8'h00);

        // R3 / R2: pulse beats clear, latch holds, clear empties
        req_en = 32'h0000_0008;
        pulse(32'h0000_0008);
        req_pulse = 32'h0000_0008;
        req_clr   = 32'h0000_0008;
        tick();
        req_pulse = '0; req_clr = '0;
        #1;
        chk("R3 pulse wins clear", {7'd0, irq}, 8'h01);
        tick(); tick(); tick();
        chk("R2 hold", {7'd0, irq}, 8'h01);
        clear(32'h0000_0008);
        #1;
        chk("R3 clear", {7'd0, irq}, 8'h00);
        req_en = 32'h0000_0000;
        pulse(32'h0000_0010);
        #1;
        chk("R4 disabled", {7'd0, irq}, 8'h00);

        // R9: late higher-priority request does not redirect
        clear(32'hFFFF_FFFF);
        req_en = 32'hFFFF_FFFF;
        pulse(32'h0000_0400);
        fetch_at(16'h0043, mem_byte(16'h0043), "R9 opcode");
        pulse(32'h0000_0001);
        fetch_at(16'h0044, mem_byte(16'h0044), "R9 page");
        fetch_at(16'h0045, 8'h28, "R9 held vector");
        // R11: sequence closed
        fetch_at(16'h0045, mem_byte(16'h0045), "R11 closed");
        fetch_at(16'h0043, mem_byte(16'h0043), "R6 reopen");
        fetch_at(16'h0045, 8'h00, "R6 new winner");

        // R8: autovector disabled
        av_en = 1'b0;
        fetch_at(16'h0043, mem_byte(16'h0043), "R8 opcode");
        fetch_at(16'h0044, mem_byte(16'h0044), "R8 page");
        fetch_at(16'h0045, mem_byte(16'h0045), "R8 pass");
        av_en = 1'b1;

        finish_run();
    end

endmodule